// File: doc/BRIEF.md
# Seconds Counter with Alarm

A real-time seconds counter mapped onto a simple synchronous register bus. A 15-bit prescaler advances on each pulse of a 32.768 kHz tick enable. Each time its top bit falls from 1 to 0, a 32-bit seconds register advances by one. A compare register raises an alarm flag. The flag is raised on the second that follows a match, not on the match itself. Wrapping the seconds register raises an overflow flag. A time-invalid flag is set out of reset and remains set until software loads a time.

Software stops the counter, loads the seconds and prescaler registers, and then starts it again. Counter writes made while it runs have no effect. The alarm and overflow flags are each masked by their own enable bit and combined onto one interrupt line. A control bit decides whether non-privileged bus writes are accepted.

Register map (word index on `addr_i`):
- 0: seconds
- 1: prescaler (bits 14:0)
- 2: alarm compare
- 3: status
- 4: interrupt enable
- 5: control

Status bits:
- bit 0: time invalid
- bit 1: overflow
- bit 2: alarm
- bit 4: run (the only status bit that is writable)

Interrupt enable bits:
- bit 0: alarm
- bit 1: overflow

Control bits:
- bit 0: allow non-privileged writes

Top module: `sec_timer`

## Requirements
- R1: After reset the registers read as follows: seconds 0, prescaler 0, alarm 0xFFFFFFFF, status 0x1 (only time-invalid set), interrupt enable 0, control 0. `irq_o` is 0.
- R2: While run (status bit 4) is 1, each cycle with `tick_i` high advances the prescaler by one. The seconds register advances by one when prescaler bit 14 goes from 1 to 0. While run is 0, ticks change nothing.
- R3: A write to the seconds register (0) or the prescaler register (1) while run is 1 leaves that register unchanged.
- R4: While run is 0, a prescaler write that changes bit 14 from 1 to 0 also advances the seconds register by one. Other prescaler writes do not.
- R5: The alarm flag (status bit 2) is set only when the seconds register advances from a value equal to the alarm register. The seconds register merely equalling the alarm register does not set it.
- R6: Any write to the alarm register (2) clears the alarm flag.
- R7: When the seconds register advances from 0xFFFFFFFF to 0, the overflow flag (status bit 1) is set and run is cleared in the same cycle.
- R8: Time-invalid (status bit 0) is set by reset. A write to the seconds register clears both time-invalid and overflow. While either flag is set, run cannot be set to 1.
- R9: `irq_o` is 1 exactly when (alarm flag AND enable bit 0) or (overflow flag AND enable bit 1) holds. Writing 0 to the interrupt enable register (4) forces `irq_o` to 0.
- R10: Writes with `priv_i` = 0 are ignored unless control bit 0 is 1. The control register (5) accepts writes only when `priv_i` = 1.
- R11: `rdata_o` shows the register selected by `addr_i` in the same cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle per tick |
| we_i | input | 1 | Write strobe |
| priv_i | input | 1 | Access is privileged |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The assertions assume the following about the inputs:
- `tick_i` is already synchronous to `clk_i`.
- Each bus write lasts exactly one cycle, so a seconds write and a prescaler carry never fall in the same cycle.

The bench respects both conditions. It drives all inputs only on the falling clock edge and holds the write strobe high for a single cycle. It never issues a tick and a write in the same cycle. The prescaler is preloaded close to its carry point, so that the alarm and wrap corner cases are reached in a few ticks rather than thousands.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned PRESC_W = 15;

  localparam logic [ADDR_W-1:0] A_SECS  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 3'd1;
  localparam logic [ADDR_W-1:0] A_ALARM = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;

  localparam int unsigned ST_INV = 0;
  localparam int unsigned ST_OVF = 1;
  localparam int unsigned ST_ALM = 2;
  localparam int unsigned ST_RUN = 4;
  localparam int unsigned IE_ALM = 0;
  localparam int unsigned IE_OVF = 1;
  localparam int unsigned CT_USR = 0;
endpackage

// File: rtl/sec_timer_presc.sv
module sec_timer_presc #(
  parameter int unsigned PRESC_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic               wr_i,
  input  logic [PRESC_W-1:0] wdata_i,
  output logic [PRESC_W-1:0] value_o,
  output logic               carry_o
);
  localparam int unsigned TAP = PRESC_W - 1;

  logic [PRESC_W-1:0] value_q, value_d;

  always_comb begin
    if (wr_i)                 value_d = wdata_i;
    else if (run_i && tick_i) value_d = value_q + 1'b1;
    else                      value_d = value_q;
  end

  // carry on falling tap bit, whether from counting or from a write
  assign carry_o = value_q[TAP] & ~value_d[TAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) value_q <= '0;
    else         value_q <= value_d;
  end

  assign value_o = value_q;

  assert_presc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_i) |=> $stable(value_q));
endmodule

// File: rtl/sec_timer_count.sv
module sec_timer_count #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_secs_i,
  input  logic             wr_alarm_i,
  input  logic [SEC_W-1:0] wdata_i,
  output logic [SEC_W-1:0] secs_o,
  output logic [SEC_W-1:0] alarm_o,
  output logic             inv_o,
  output logic             ovf_o,
  output logic             alm_o,
  output logic             wrap_o
);
  logic [SEC_W-1:0] secs_q, alarm_q;
  logic             inv_q, ovf_q, alm_q;
  logic             hit;

  assign wrap_o = inc_i && (secs_q == '1);
  assign hit    = inc_i && (secs_q == alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secs_q  <= '0;
      alarm_q <= '1;
      inv_q   <= 1'b1;
      ovf_q   <= 1'b0;
      alm_q   <= 1'b0;
    end else begin
      if (wr_secs_i) begin
        secs_q <= wdata_i;
        inv_q  <= 1'b0;
        ovf_q  <= 1'b0;
      end else if (inc_i) begin
        secs_q <= secs_q + 1'b1;
        if (wrap_o) ovf_q <= 1'b1;
      end
      if (wr_alarm_i) begin
        alarm_q <= wdata_i;
        alm_q   <= 1'b0;
      end else if (hit) begin
        alm_q <= 1'b1;
      end
    end
  end

  assign secs_o  = secs_q;
  assign alarm_o = alarm_q;
  assign inv_o   = inv_q;
  assign ovf_o   = ovf_q;
  assign alm_o   = alm_q;

  assert_alarm_on_inc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_q && !$past(alm_q)) |-> ($past(inc_i) && $past(secs_q) == $past(alarm_q)));
  assert_ovf_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !$past(ovf_q)) |-> (secs_q == '0));
  assert_alarm_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_alarm_i |=> !alm_q);
endmodule

// File: rtl/sec_timer_regs.sv
module sec_timer_regs
  import sec_timer_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned PW = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     secs_i,
  input  logic [PW-1:0]     presc_i,
  input  logic [DW-1:0]     alarm_i,
  input  logic              inv_i,
  input  logic              ovf_i,
  input  logic              alm_i,
  input  logic              wrap_i,
  output logic              run_o,
  output logic              wr_secs_o,
  output logic              wr_presc_o,
  output logic              wr_alarm_o,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic       run_q, usr_q;
  logic [1:0] ien_q;
  logic       wr_ok;

  assign wr_ok      = we_i && (priv_i || usr_q);
  assign wr_secs_o  = wr_ok && !run_q && (addr_i == A_SECS);
  assign wr_presc_o = wr_ok && !run_q && (addr_i == A_PRESC);
  assign wr_alarm_o = wr_ok && (addr_i == A_ALARM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      usr_q <= 1'b0;
      ien_q <= '0;
    end else begin
      if (wrap_i)
        run_q <= 1'b0;
      else if (wr_ok && addr_i == A_STAT)
        run_q <= wdata_i[ST_RUN] && !inv_i && !ovf_i;
      if (we_i && priv_i && addr_i == A_CTRL) usr_q <= wdata_i[CT_USR];
      if (wr_ok && addr_i == A_IEN) ien_q <= wdata_i[1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_SECS:  rdata_o = secs_i;
      A_PRESC: rdata_o = {{(DW-PW){1'b0}}, presc_i};
      A_ALARM: rdata_o = alarm_i;
      A_STAT: begin
        rdata_o[ST_INV] = inv_i;
        rdata_o[ST_OVF] = ovf_i;
        rdata_o[ST_ALM] = alm_i;
        rdata_o[ST_RUN] = run_q;
      end
      A_IEN:   rdata_o[1:0] = ien_q;
      A_CTRL:  rdata_o[CT_USR] = usr_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = (alm_i && ien_q[IE_ALM]) || (ovf_i && ien_q[IE_OVF]);
  assign run_o = run_q;

  assert_no_run_bad_time_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i || ovf_i) |-> !run_q);
  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == 2'b00) |-> !irq_o);
  assert_ctrl_priv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> $stable(usr_q));
endmodule

// File: rtl/sec_timer.sv
module sec_timer
  import sec_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [PRESC_W-1:0] presc;
  logic [DATA_W-1:0]  secs, alarm;
  logic carry, run, wr_secs, wr_presc, wr_alarm, inv, ovf, alm, wrap;

  sec_timer_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .tick_i  (tick_i),
    .wr_i    (wr_presc),
    .wdata_i (wdata_i[PRESC_W-1:0]),
    .value_o (presc),
    .carry_o (carry)
  );

  sec_timer_count #(.SEC_W(DATA_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (carry),
    .wr_secs_i  (wr_secs),
    .wr_alarm_i (wr_alarm),
    .wdata_i    (wdata_i),
    .secs_o     (secs),
    .alarm_o    (alarm),
    .inv_o      (inv),
    .ovf_o      (ovf),
    .alm_o      (alm),
    .wrap_o     (wrap)
  );

  sec_timer_regs #(.DW(DATA_W), .PW(PRESC_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .priv_i     (priv_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .secs_i     (secs),
    .presc_i    (presc),
    .alarm_i    (alarm),
    .inv_i      (inv),
    .ovf_i      (ovf),
    .alm_i      (alm),
    .wrap_i     (wrap),
    .run_o      (run),
    .wr_secs_o  (wr_secs),
    .wr_presc_o (wr_presc),
    .wr_alarm_o (wr_alarm),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o)
  );

  assert_secs_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !carry) |=> $stable(secs));
endmodule

// File: tb/sec_timer_bench.sv
module sec_timer_bench;
  import sec_timer_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2, OP_I = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VEC [NV] = '{
    '{OP_R, A_STAT,  32'h1,        4'd8},   // R8 invalid after reset
    '{OP_W, A_STAT,  32'h10,       4'd0},
    '{OP_R, A_STAT,  32'h1,        4'd8},   // R8 run refused
    '{OP_W, A_SECS,  32'd5,        4'd0},
    '{OP_R, A_STAT,  32'h0,        4'd8},   // R8 invalid cleared
    '{OP_R, A_SECS,  32'd5,        4'd11},  // R11
    '{OP_W, A_PRESC, 32'h7FFE,     4'd0},
    '{OP_R, A_PRESC, 32'h7FFE,     4'd11},  // R11
    '{OP_W, A_ALARM, 32'd6,        4'd0},
    '{OP_W, A_IEN,   32'h1,        4'd0},
    '{OP_W, A_STAT,  32'h10,       4'd0},
    '{OP_R, A_STAT,  32'h10,       4'd2},   // R2 running
    '{OP_W, A_SECS,  32'd99,       4'd0},
    '{OP_R, A_SECS,  32'd5,        4'd3},   // R3
    '{OP_W, A_PRESC, 32'h0,        4'd0},
    '{OP_R, A_PRESC, 32'h7FFE,     4'd3},   // R3
    '{OP_T, 3'd0,    32'd1,        4'd0},
    '{OP_R, A_PRESC, 32'h7FFF,     4'd2},   // R2
    '{OP_R, A_SECS,  32'd5,        4'd2},   // R2
    '{OP_T, 3'd0,    32'd1,        4'd0},
    '{OP_R, A_PRESC, 32'h0,        4'd2},   // R2
    '{OP_R, A_SECS,  32'd6,        4'd2},   // R2
    '{OP_R, A_STAT,  32'h10,       4'd5},   // R5 equality alone
    '{OP_I, 3'd0,    32'd0,        4'd5},   // R5
    '{OP_W, A_STAT,  32'h0,        4'd0},
    '{OP_W, A_PRESC, 32'h7FFF,     4'd0},
    '{OP_W, A_STAT,  32'h10,       4'd0},
    '{OP_T, 3'd0,    32'd1,        4'd0},
    '{OP_R, A_SECS,  32'd7,        4'd5},   // R5
    '{OP_R, A_STAT,  32'h14,       4'd5},   // R5 alarm set
    '{OP_I, 3'd0,    32'd1,        4'd9},   // R9
    '{OP_W, A_ALARM, 32'd100,      4'd0},
    '{OP_R, A_STAT,  32'h10,       4'd6},   // R6
    '{OP_I, 3'd0,    32'd0,        4'd6},   // R6
    '{OP_W, A_STAT,  32'h0,        4'd0},
    '{OP_W, A_PRESC, 32'h4000,     4'd0},
    '{OP_W, A_PRESC, 32'h0,        4'd0},
    '{OP_R, A_SECS,  32'd8,        4'd4},   // R4 falling bit 14
    '{OP_W, A_PRESC, 32'h3FFF,     4'd0},
    '{OP_R, A_SECS,  32'd8,        4'd4},   // R4 no fall
    '{OP_W, A_SECS,  32'hFFFFFFFF, 4'd0},
    '{OP_W, A_PRESC, 32'h7FFF,     4'd0},
    '{OP_W, A_IEN,   32'h2,        4'd0},
    '{OP_W, A_STAT,  32'h10,       4'd0},
    '{OP_T, 3'd0,    32'd1,        4'd0},
    '{OP_R, A_SECS,  32'h0,        4'd7},   // R7 wrap
    '{OP_R, A_STAT,  32'h2,        4'd7},   // R7 ovf, run cleared
    '{OP_I, 3'd0,    32'd1,        4'd9},   // R9
    '{OP_W, A_STAT,  32'h10,       4'd0},
    '{OP_R, A_STAT,  32'h2,        4'd8},   // R8 run refused on ovf
    '{OP_W, A_IEN,   32'h0,        4'd0},
    '{OP_I, 3'd0,    32'd0,        4'd9},   // R9 all disabled
    '{OP_W, A_SECS,  32'd3,        4'd0},
    '{OP_R, A_STAT,  32'h0,        4'd8},   // R8 ovf cleared
    '{OP_T, 3'd0,    32'd3,        4'd0},
    '{OP_R, A_PRESC, 32'h0,        4'd2}    // R2 stopped
  };

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0, priv = 1'b1;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_timer u_sec_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .priv_i(priv),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, input logic p);
    @(negedge clk); we = 1'b1; addr = a; wdata = d; priv = p;
    @(negedge clk); we = 1'b0; priv = 1'b1;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [31:0] exp, input int r);
    @(negedge clk); addr = a; #1;
    n_run++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL R%0d addr=%0d actual=%h expected=%h", r, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input int r);
    @(negedge clk); #1;
    n_run++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL R%0d irq actual=%b expected=%b", r, irq, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_W: bus_wr(VEC[i].addr, VEC[i].data, 1'b1);
        OP_R: chk_rd(VEC[i].addr, VEC[i].data, int'(VEC[i].req));
        OP_T: ticks(int'(VEC[i].data));
        default: chk_irq(VEC[i].data[0], int'(VEC[i].req));
      endcase
    end

    // R10 privilege gating; counter is stopped, seconds = 3
    bus_wr(A_SECS, 32'd77, 1'b0);
    chk_rd(A_SECS, 32'd3, 10);            // R10 user write ignored
    bus_wr(A_CTRL, 32'h1, 1'b1);
    chk_rd(A_CTRL, 32'h1, 10);            // R10
    bus_wr(A_SECS, 32'd77, 1'b0);
    chk_rd(A_SECS, 32'd77, 10);           // R10 user write allowed
    bus_wr(A_CTRL, 32'h0, 1'b0);
    chk_rd(A_CTRL, 32'h1, 10);            // R10 ctrl needs privilege
    chk_rd(3'd7, 32'h0, 11);              // R11 unmapped

    // R1 reset state
    bus_wr(A_IEN, 32'h3, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_rd(A_SECS,  32'h0,        1);     // R1
    chk_rd(A_PRESC, 32'h0,        1);     // R1
    chk_rd(A_ALARM, 32'hFFFFFFFF, 1);     // R1
    chk_rd(A_STAT,  32'h1,        1);     // R1
    chk_rd(A_IEN,   32'h0,        1);     // R1
    chk_rd(A_CTRL,  32'h0,        1);     // R1
    chk_irq(1'b0, 1);                     // R1

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule